// File: doc/BRIEF.md
# Transmit Descriptor Ring Gatherer

This block serves one transmit channel. It walks a circular ring of 8-byte descriptors held in word-addressed shared memory. It collects the buffers of a packet that may span several descriptors and turns them into a byte stream with start and end markers. It appends zero pad bytes, hands descriptors back to software by writing zero over their control word, and pulses a completion event for each packet sent.

Software programs the ring bounds and loads the current pointer. A `kick` pulse then starts a scan pass. A pass sends packets back to back. It ends at the first packet whose head descriptor is not owned, after an abandoned packet, or once `PASS_MAX` packets have been sent. A mode input selects one of two descriptor dialects. The dialects differ in how the segment length is encoded and in how the ring pointer wraps.

Descriptor control word (word 0): bit 31 owned by hardware, bit 30 first segment, bit 29 last segment, bits [25:24] length trim, bits [23:22] pad code, bit 20 trim enable, bits [11:0] length. Word 1 (at descriptor address + 4) is the buffer byte address, which must be a multiple of 4.

Top module: `txdesc_gather`

## Requirements
- R1: A `kick` while idle reads word 0 at the current pointer. If bit 31 is clear, the pass ends with no memory write, no output byte and no `tx_done`, and the pointer does not move.
- R2: With `mode_words`=0, a segment carries exactly bits [11:0] of word 0 in bytes.
- R3: With `mode_words`=1, a segment carries bits [11:0] times 4 bytes. When bit 20 is set, the value of bits [25:24] is subtracted (floored at zero). When bit 20 is clear, bits [25:24] have no effect.
- R4: Buffer bytes leave in address order, little-endian within each memory word. The first byte of a packet has `out_sop`=1 and its final byte has `out_eop`=1.
- R5: After the last segment (bit 29 set), (pad code − 1) mod 4 zero bytes are appended, using that descriptor's bits [23:22]. No pad is added when the gathered length is zero.
- R6: A descriptor with bit 30 clear has word 0 overwritten with zero once its data is consumed. The head descriptor's word 0 is overwritten with zero after the packet's last byte has been emitted.
- R7: Pointer advance in mode 0: the next pointer is current + 8, replaced by `ring_start` if it equals `ring_end`. In mode 1: `ring_start` if current equals `ring_end`, otherwise current + 8.
- R8: If a later descriptor of a packet is not owned, the packet is abandoned. If any byte was already produced, one beat with `out_eop`=1 and `out_abort`=1 ends it. The head descriptor is left unchanged, no `tx_done` is raised, the pass ends, and the pointer rests on the unowned descriptor.
- R9: A pass sends at most `PASS_MAX` (default 16) packets and then goes idle.
- R10: Each completed packet gives a one-cycle `tx_done` pulse. This includes a packet of total length zero, which emits no bytes.
- R11: `ring_load` while idle sets the current pointer to `ring_start`.
- R12: A memory request keeps `mem_req`, `mem_addr` and `mem_we` unchanged until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_words | input | 1 | Descriptor dialect select (0 or 1) |
| ring_load | input | 1 | Load current pointer from ring_start |
| ring_start | input | AW | Byte address of first descriptor |
| ring_end | input | AW | Ring end marker, meaning set by mode |
| kick | input | 1 | Start a scan pass |
| pass_busy | output | 1 | A scan pass is in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete, read data valid |
| mem_rdata | input | 32 | Read data |
| out_valid | output | 1 | Output byte valid |
| out_byte | output | 8 | Output byte |
| out_sop | output | 1 | First byte of packet |
| out_eop | output | 1 | Final beat of packet |
| out_abort | output | 1 | Packet abandoned, discard |
| tx_done | output | 1 | Packet completed pulse |

## Verification
The assertions assume that `mem_ack` arrives only while `mem_req` is high, and that `ring_start`, `ring_end` and `mode_words` stay steady during a pass. The bench's memory model acknowledges only pending requests. It varies the wait from zero to two cycles so that the request-hold property is actually exercised. The bench rewrites ring bounds, mode and descriptor contents only between passes, while `pass_busy` is low.

// File: rtl/txg_pkg.sv
package txg_pkg;
  localparam int OWN_B   = 31;
  localparam int FS_B    = 30;
  localparam int LS_B    = 29;
  localparam int TRIM_LO = 24;
  localparam int PAD_LO  = 22;
  localparam int TRIM_EN = 20;
  localparam int LEN_W   = 12;
  localparam int SEG_W   = LEN_W + 2;
  localparam int DESC_BYTES = 8;

  typedef enum logic [3:0] {
    S_IDLE, S_RD0, S_RD1, S_DATA, S_BYTES, S_CLR, S_ADV, S_PAD, S_FIN
  } txg_state_e;

  typedef struct packed {
    logic             own;
    logic             fs;
    logic             ls;
    logic [SEG_W-1:0] seg_len;
    logic [1:0]       pad_add;
  } txg_desc_t;
endpackage

// File: rtl/txg_desc_decode.sv
module txg_desc_decode
  import txg_pkg::*;
(
  input  logic [31:0] word0,
  input  logic        mode_words,
  output txg_desc_t   info
);
  logic [SEG_W-1:0] scaled;
  logic [SEG_W-1:0] trim;
  logic             unused_rsvd;

  assign unused_rsvd = ^{word0[28:26], word0[21], word0[19:12]};

  always_comb begin
    scaled = {word0[LEN_W-1:0], 2'b00};
    trim   = word0[TRIM_EN] ? SEG_W'(word0[TRIM_LO +: 2]) : '0;
    info.own = word0[OWN_B];
    info.fs  = word0[FS_B];
    info.ls  = word0[LS_B];
    if (mode_words) begin
      info.seg_len = (scaled < trim) ? '0 : scaled - trim;
    end else begin
      info.seg_len = SEG_W'(word0[LEN_W-1:0]);
    end
    info.pad_add = word0[PAD_LO +: 2] - 2'd1;
  end
endmodule

// File: rtl/txg_ring_ptr.sv
module txg_ring_ptr
  import txg_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          mode_words,
  input  logic [AW-1:0] ring_start,
  input  logic [AW-1:0] ring_end,
  output logic [AW-1:0] cur
);
  logic [AW-1:0] inc;
  logic [AW-1:0] wrapped;
  logic [AW-1:0] cur_n;

  always_comb begin
    inc = cur + AW'(DESC_BYTES);
    if (mode_words) wrapped = (cur == ring_end) ? ring_start : inc;
    else            wrapped = (inc == ring_end) ? ring_start : inc;
    cur_n = cur;
    if (load)      cur_n = ring_start;
    else if (step) cur_n = wrapped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= '0;
    else        cur <= cur_n;
  end

  p_step_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (cur == ring_start) || (cur == $past(cur) + AW'(DESC_BYTES)));
endmodule

// File: rtl/txg_byte_emit.sv
module txg_byte_emit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic [7:0] push_byte,
  input  logic       close,
  input  logic       abort,
  output logic       out_valid,
  output logic [7:0] out_byte,
  output logic       out_sop,
  output logic       out_eop,
  output logic       out_abort
);
  logic       hold_v, hold_v_n;
  logic [7:0] hold_d, hold_d_n;
  logic       hold_first, hold_first_n;
  logic       ov_n, sop_n, eop_n, ab_n;
  logic [7:0] ob_n;
  logic       in_pkt;

  always_comb begin
    hold_v_n = hold_v; hold_d_n = hold_d; hold_first_n = hold_first;
    ov_n = 1'b0; ob_n = out_byte; sop_n = 1'b0; eop_n = 1'b0; ab_n = 1'b0;
    if (push) begin
      ov_n  = hold_v;
      ob_n  = hold_d;
      sop_n = hold_v && hold_first;
      hold_d_n     = push_byte;
      hold_v_n     = 1'b1;
      hold_first_n = !hold_v;
    end else if (close || abort) begin
      ov_n  = hold_v;
      ob_n  = hold_d;
      sop_n = hold_v && hold_first;
      eop_n = hold_v;
      ab_n  = hold_v && abort;
      hold_v_n     = 1'b0;
      hold_first_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v <= 1'b0; hold_d <= '0; hold_first <= 1'b0;
      out_valid <= 1'b0; out_byte <= '0; out_sop <= 1'b0;
      out_eop <= 1'b0; out_abort <= 1'b0;
    end else begin
      hold_v <= hold_v_n; hold_d <= hold_d_n; hold_first <= hold_first_n;
      out_valid <= ov_n; out_byte <= ob_n; out_sop <= sop_n;
      out_eop <= eop_n; out_abort <= ab_n;
    end
  end

  // framing tracker for the checks below
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         in_pkt <= 1'b0;
    else if (out_valid) in_pkt <= !out_eop;
  end

  p_sop_opens_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sop) |-> !in_pkt);
  p_body_inside_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sop) |-> in_pkt);
endmodule

// File: rtl/txdesc_gather.sv
module txdesc_gather
  import txg_pkg::*;
#(
  parameter int AW       = 32,
  parameter int PASS_MAX = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_words,
  input  logic          ring_load,
  input  logic [AW-1:0] ring_start,
  input  logic [AW-1:0] ring_end,
  input  logic          kick,
  output logic          pass_busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          out_valid,
  output logic [7:0]    out_byte,
  output logic          out_sop,
  output logic          out_eop,
  output logic          out_abort,
  output logic          tx_done
);
  localparam int CNT_W = $clog2(PASS_MAX + 1);

  logic [1:0] rst_sync;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  txg_state_e       state, state_n;
  logic [31:0]      w0, w0_n;
  logic [AW-1:0]    head_addr, head_addr_n;
  logic [AW-1:0]    buf_addr, buf_addr_n;
  logic [SEG_W-1:0] rem, rem_n;
  logic [31:0]      wbuf, wbuf_n;
  logic [1:0]       bidx, bidx_n;
  logic [1:0]       pad_left, pad_left_n;
  logic             is_head, is_head_n;
  logic             got_data, got_data_n;
  logic [CNT_W-1:0] pkt_cnt, pkt_cnt_n;
  logic             done_q, done_n;

  logic             step, load;
  logic             push, close, abort;
  logic [7:0]       push_byte;
  logic [AW-1:0]    cur;
  txg_desc_t        dinfo;
  txg_state_e       seg_exit;
  logic             unused_low;

  assign unused_low = ^buf_addr[1:0];
  assign pass_busy  = (state != S_IDLE);
  assign load       = ring_load && (state == S_IDLE);
  assign tx_done    = done_q;
  assign seg_exit   = dinfo.fs ? S_ADV : S_CLR;

  txg_desc_decode u_dec (
    .word0      (w0),
    .mode_words (mode_words),
    .info       (dinfo)
  );

  txg_ring_ptr #(.AW(AW)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_ni),
    .load       (load),
    .step       (step),
    .mode_words (mode_words),
    .ring_start (ring_start),
    .ring_end   (ring_end),
    .cur        (cur)
  );

  txg_byte_emit u_emit (
    .clk       (clk),
    .rst_n     (rst_ni),
    .push      (push),
    .push_byte (push_byte),
    .close     (close),
    .abort     (abort),
    .out_valid (out_valid),
    .out_byte  (out_byte),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .out_abort (out_abort)
  );

  always_comb begin
    state_n = state; w0_n = w0; head_addr_n = head_addr; buf_addr_n = buf_addr;
    rem_n = rem; wbuf_n = wbuf; bidx_n = bidx; pad_left_n = pad_left;
    is_head_n = is_head; got_data_n = got_data; pkt_cnt_n = pkt_cnt;
    done_n = 1'b0;
    mem_req = 1'b0; mem_we = 1'b0; mem_addr = '0; mem_wdata = '0;
    push = 1'b0; push_byte = '0; close = 1'b0; abort = 1'b0; step = 1'b0;
    case (state)
      S_IDLE: begin
        if (kick) begin
          pkt_cnt_n = '0;
          is_head_n = 1'b1;
          state_n   = S_RD0;
        end
      end
      S_RD0: begin
        mem_req  = 1'b1;
        mem_addr = cur;
        if (mem_ack) begin
          w0_n = mem_rdata;
          if (!mem_rdata[OWN_B]) begin
            abort   = !is_head;
            state_n = S_IDLE;
          end else begin
            if (is_head) begin
              head_addr_n = cur;
              got_data_n  = 1'b0;
            end
            state_n = S_RD1;
          end
        end
      end
      S_RD1: begin
        mem_req  = 1'b1;
        mem_addr = cur + AW'(4);
        if (mem_ack) begin
          buf_addr_n = mem_rdata[AW-1:0];
          rem_n      = dinfo.seg_len;
          state_n    = (dinfo.seg_len == '0) ? seg_exit : S_DATA;
        end
      end
      S_DATA: begin
        mem_req  = 1'b1;
        mem_addr = {buf_addr[AW-1:2], 2'b00};
        if (mem_ack) begin
          wbuf_n  = mem_rdata;
          bidx_n  = 2'd0;
          state_n = S_BYTES;
        end
      end
      S_BYTES: begin
        push       = 1'b1;
        push_byte  = wbuf[{bidx, 3'b000} +: 8];
        got_data_n = 1'b1;
        rem_n      = rem - SEG_W'(1);
        bidx_n     = bidx + 2'd1;
        if (rem == SEG_W'(1)) begin
          state_n = seg_exit;
        end else if (bidx == 2'd3) begin
          buf_addr_n = buf_addr + AW'(4);
          state_n    = S_DATA;
        end
      end
      S_CLR: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = cur;
        if (mem_ack) state_n = S_ADV;
      end
      S_ADV: begin
        step = 1'b1;
        if (dinfo.ls) begin
          pad_left_n = got_data ? dinfo.pad_add : 2'd0;
          state_n    = S_PAD;
        end else begin
          is_head_n = 1'b0;
          state_n   = S_RD0;
        end
      end
      S_PAD: begin
        if (pad_left != 2'd0) begin
          push       = 1'b1;
          pad_left_n = pad_left - 2'd1;
        end else begin
          close   = 1'b1;
          state_n = S_FIN;
        end
      end
      S_FIN: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = head_addr;
        if (mem_ack) begin
          done_n    = 1'b1;
          pkt_cnt_n = pkt_cnt + CNT_W'(1);
          if (pkt_cnt == CNT_W'(PASS_MAX - 1)) begin
            state_n = S_IDLE;
          end else begin
            is_head_n = 1'b1;
            state_n   = S_RD0;
          end
        end
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= S_IDLE; w0 <= '0; head_addr <= '0; buf_addr <= '0;
      rem <= '0; wbuf <= '0; bidx <= '0; pad_left <= '0;
      is_head <= 1'b0; got_data <= 1'b0; pkt_cnt <= '0; done_q <= 1'b0;
    end else begin
      state <= state_n; w0 <= w0_n; head_addr <= head_addr_n; buf_addr <= buf_addr_n;
      rem <= rem_n; wbuf <= wbuf_n; bidx <= bidx_n; pad_left <= pad_left_n;
      is_head <= is_head_n; got_data <= got_data_n; pkt_cnt <= pkt_cnt_n;
      done_q <= done_n;
    end
  end

  // completions since the pass began, kept apart from the sequencer's own count
  logic [CNT_W-1:0] chk_cnt;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)                 chk_cnt <= '0;
    else if (kick && !pass_busy) chk_cnt <= '0;
    else if (tx_done)            chk_cnt <= chk_cnt + CNT_W'(1);
  end

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    tx_done |=> !tx_done);
  p_pass_cap_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    tx_done |-> (chk_cnt < CNT_W'(PASS_MAX)));
  p_word_len_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode_words && state == S_RD1 && mem_ack && !w0[TRIM_EN]) |=> (rem[1:0] == 2'b00));
endmodule

// File: tb/txdesc_gather_bench.sv
module txdesc_gather_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_words, ring_load, kick;
  logic [31:0] ring_start, ring_end;
  logic        pass_busy, mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        out_valid, out_sop, out_eop, out_abort, tx_done;
  logic [7:0]  out_byte;

  always #5 clk = ~clk;

  txdesc_gather u_txdesc_gather (
    .clk(clk), .rst_n(rst_n), .mode_words(mode_words), .ring_load(ring_load),
    .ring_start(ring_start), .ring_end(ring_end), .kick(kick), .pass_busy(pass_busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .out_valid(out_valid), .out_byte(out_byte),
    .out_sop(out_sop), .out_eop(out_eop), .out_abort(out_abort), .tx_done(tx_done)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [31:0] mem [0:511];
  int wcnt = 0, lat = 0, viol = 0;
  bit pend = 0;
  logic [31:0] p_addr;
  logic p_we;

  // memory model: 0..2 wait cycles, checks request stability
  always @(negedge clk) begin
    bit acking;
    acking = 0;
    if (pend && (!mem_req || mem_addr != p_addr || mem_we != p_we)) viol++;
    if (!rst_n) begin
      mem_ack <= 1'b0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (wcnt == lat) begin
        acking = 1;
        if (mem_we) mem[mem_addr[10:2]] = mem_wdata;
        mem_rdata <= mem[mem_addr[10:2]];
        mem_ack <= 1'b1;
        wcnt = 0;
        lat = (lat == 2) ? 0 : lat + 1;
      end else begin
        wcnt = wcnt + 1;
      end
    end
    pend = rst_n && mem_req && !mem_ack && !acking;
    p_addr = mem_addr;
    p_we = mem_we;
  end

  logic [7:0] cap_d [0:63];
  bit cap_s [0:63], cap_e [0:63], cap_a [0:63];
  int cap_n = 0, done_cnt = 0;

  always @(negedge clk) begin
    if (out_valid && cap_n < 64) begin
      cap_d[cap_n] = out_byte; cap_s[cap_n] = out_sop;
      cap_e[cap_n] = out_eop; cap_a[cap_n] = out_abort;
      cap_n++;
    end
    if (tx_done) done_cnt++;
  end

  logic [7:0] exp_d [0:63];
  bit exp_s [0:63], exp_e [0:63], exp_a [0:63];
  int exp_n = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] mkw0(bit own, bit fs, bit ls, int len, int pad, bit ten, int trim);
    return {own, fs, ls, 3'b000, trim[1:0], pad[1:0], 1'b0, ten, 8'h00, len[11:0]};
  endfunction

  task automatic put_desc(input int addr, input logic [31:0] w0, input int bufa);
    mem[addr >> 2] = w0;
    mem[(addr >> 2) + 1] = bufa;
  endtask

  task automatic fill_buf(input int addr, input int n, input int first);
    for (int i = 0; i < n; i++) begin
      int a;
      a = addr + i;
      mem[a >> 2][(a & 3) * 8 +: 8] = 8'(first + i);
    end
  endtask

  task automatic exp_pkt(input int first, input int n, input int zeros, input bit ab);
    int tot;
    tot = n + zeros;
    for (int i = 0; i < tot; i++) begin
      exp_d[exp_n] = (i < n) ? 8'(first + i) : 8'h00;
      exp_s[exp_n] = (i == 0);
      exp_e[exp_n] = (i == tot - 1);
      exp_a[exp_n] = ab && (i == tot - 1);
      exp_n++;
    end
  endtask

  task automatic clr_cap;
    cap_n = 0; done_cnt = 0; exp_n = 0;
  endtask

  task automatic check_stream(input string tag);
    chk(cap_n == exp_n, {tag, " beat count"}, cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++) begin
      chk(cap_d[i] == exp_d[i], {tag, " byte"}, cap_d[i], exp_d[i]);
      chk(cap_s[i] == exp_s[i] && cap_e[i] == exp_e[i] && cap_a[i] == exp_a[i],
          {tag, " markers"}, {cap_s[i], cap_e[i], cap_a[i]}, {exp_s[i], exp_e[i], exp_a[i]});
    end
  endtask

  task automatic load_ring(input int st, input int en, input bit md);
    @(negedge clk);
    mode_words = md; ring_start = st; ring_end = en; ring_load = 1'b1;
    @(negedge clk);
    ring_load = 1'b0;
  endtask

  task automatic run_pass;
    @(negedge clk); kick = 1'b1;
    @(negedge clk); kick = 1'b0;
    while (pass_busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(!mem_req && !out_valid && !tx_done && !pass_busy, "R1 reset outputs idle",
        {mem_req, out_valid, tx_done, pass_busy}, 0);
  endtask

  task automatic t_head_unowned;
    put_desc(32'h000, mkw0(0, 1, 1, 3, 1, 0, 0), 32'h400);
    put_desc(32'h008, 32'h0, 32'h0);
    fill_buf(32'h400, 3, 8'h10);
    load_ring(32'h000, 32'h010, 0);
    clr_cap(); run_pass();
    chk(cap_n == 0 && done_cnt == 0, "R1 unowned head sends nothing", cap_n + done_cnt, 0);
    chk(mem[0] == mkw0(0, 1, 1, 3, 1, 0, 0), "R1 unowned head not written", mem[0], mkw0(0, 1, 1, 3, 1, 0, 0));
    mem[0] = mkw0(1, 1, 1, 3, 1, 0, 0);
    clr_cap(); run_pass();
    exp_pkt(8'h10, 3, 0, 0);
    check_stream("R11 R2 R4 pointer kept at ring start, single segment");
    chk(done_cnt == 1, "R10 one completion", done_cnt, 1);
    chk(mem[0] == 0, "R6 head word0 cleared", mem[0], 0);
  endtask

  task automatic t_multi_seg;
    put_desc(32'h040, mkw0(1, 1, 0, 3, 0, 0, 0), 32'h500);
    put_desc(32'h048, mkw0(1, 0, 0, 0, 0, 0, 0), 32'h510);
    put_desc(32'h050, mkw0(1, 0, 1, 6, 0, 0, 0), 32'h520);
    fill_buf(32'h500, 3, 8'hA0);
    fill_buf(32'h520, 6, 8'hB0);
    load_ring(32'h040, 32'h058, 0);
    clr_cap(); run_pass();
    exp_d[0] = 8'hA0; exp_n = 0;
    for (int i = 0; i < 12; i++) begin
      exp_d[i] = (i < 3) ? 8'(8'hA0 + i) : (i < 9) ? 8'(8'hB0 + i - 3) : 8'h00;
      exp_s[i] = (i == 0); exp_e[i] = (i == 11); exp_a[i] = 0;
    end
    exp_n = 12;
    check_stream("R5 R2 gathered three segments plus three pad zeros");
    chk(mem[32'h040 >> 2] == 0 && mem[32'h048 >> 2] == 0 && mem[32'h050 >> 2] == 0,
        "R6 all three word0 cleared", mem[32'h048 >> 2], 0);
    chk(done_cnt == 1, "R10 multi segment completion", done_cnt, 1);
  endtask

  task automatic t_mode1;
    put_desc(32'h080, mkw0(1, 1, 1, 2, 1, 1, 3), 32'h600);
    put_desc(32'h088, mkw0(1, 1, 1, 1, 2, 0, 2), 32'h640);
    fill_buf(32'h600, 8, 8'h20);
    fill_buf(32'h640, 4, 8'h30);
    load_ring(32'h080, 32'h088, 1);
    clr_cap(); run_pass();
    exp_pkt(8'h20, 5, 0, 0);
    exp_pkt(8'h30, 4, 1, 0);
    check_stream("R3 word lengths with and without trim");
    chk(done_cnt == 2, "R3 two completions", done_cnt, 2);
    put_desc(32'h080, mkw0(1, 1, 1, 1, 1, 0, 0), 32'h660);
    fill_buf(32'h660, 4, 8'h50);
    clr_cap(); run_pass();
    exp_pkt(8'h50, 4, 0, 0);
    check_stream("R7 mode 1 wrap at last descriptor");
  endtask

  task automatic t_mode0_wrap;
    put_desc(32'h0C0, mkw0(1, 1, 1, 1, 1, 0, 0), 32'h680);
    put_desc(32'h0C8, mkw0(1, 1, 1, 1, 1, 0, 0), 32'h684);
    fill_buf(32'h680, 1, 8'h60);
    fill_buf(32'h684, 1, 8'h61);
    load_ring(32'h0C0, 32'h0D0, 0);
    clr_cap(); run_pass();
    chk(done_cnt == 2, "R7 mode 0 two packets", done_cnt, 2);
    put_desc(32'h0C0, mkw0(1, 1, 1, 2, 1, 0, 0), 32'h688);
    fill_buf(32'h688, 2, 8'h70);
    clr_cap(); run_pass();
    exp_pkt(8'h70, 2, 0, 0);
    check_stream("R7 mode 0 wrap past end");
  endtask

  task automatic t_abandon;
    put_desc(32'h100, mkw0(1, 1, 0, 2, 0, 0, 0), 32'h700);
    put_desc(32'h108, mkw0(0, 0, 1, 1, 1, 0, 0), 32'h720);
    put_desc(32'h110, 32'h0, 32'h0);
    fill_buf(32'h700, 2, 8'hC0);
    fill_buf(32'h720, 1, 8'hD0);
    load_ring(32'h100, 32'h118, 0);
    clr_cap(); run_pass();
    exp_pkt(8'hC0, 2, 0, 1);
    check_stream("R8 abandoned packet marked");
    chk(done_cnt == 0, "R8 no completion", done_cnt, 0);
    chk(mem[32'h100 >> 2] == mkw0(1, 1, 0, 2, 0, 0, 0), "R8 head left owned",
        mem[32'h100 >> 2], mkw0(1, 1, 0, 2, 0, 0, 0));
    mem[32'h108 >> 2] = mkw0(1, 0, 1, 1, 1, 0, 0);
    clr_cap(); run_pass();
    exp_pkt(8'hD0, 1, 0, 0);
    check_stream("R8 pointer rests on unowned descriptor");
    chk(mem[32'h108 >> 2] == 0 && done_cnt == 1, "R6 non-first head cleared", mem[32'h108 >> 2], 0);
  endtask

  task automatic t_pass_limit;
    for (int i = 0; i < 20; i++) begin
      put_desc(32'h200 + 8 * i, (i < 18) ? mkw0(1, 1, 1, 1, 1, 0, 0) : 32'h0, 32'h780 + 4 * i);
      fill_buf(32'h780 + 4 * i, 1, 8'h80 + i);
    end
    load_ring(32'h200, 32'h2A0, 0);
    clr_cap(); run_pass();
    chk(done_cnt == 16, "R9 pass stops at limit", done_cnt, 16);
    chk(cap_n == 16, "R9 bytes in first pass", cap_n, 16);
    clr_cap(); run_pass();
    exp_pkt(8'h90, 1, 0, 0);
    exp_pkt(8'h91, 1, 0, 0);
    check_stream("R9 second pass continues");
    chk(done_cnt == 2, "R9 remaining packets", done_cnt, 2);
  endtask

  task automatic t_zero_len;
    put_desc(32'h300, mkw0(1, 1, 1, 0, 0, 0, 0), 32'h7F0);
    load_ring(32'h300, 32'h308, 0);
    clr_cap(); run_pass();
    chk(cap_n == 0, "R5 no pad on empty packet", cap_n, 0);
    chk(done_cnt == 1, "R10 empty packet completes", done_cnt, 1);
    chk(mem[32'h300 >> 2] == 0, "R6 empty packet head cleared", mem[32'h300 >> 2], 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 32'h0;
    rst_n = 1'b0; mode_words = 1'b0; ring_load = 1'b0; kick = 1'b0;
    ring_start = '0; ring_end = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_head_unowned();
    t_multi_seg();
    t_mode1();
    t_mode0_wrap();
    t_abandon();
    t_pass_limit();
    t_zero_len();
    chk(viol == 0, "R12 request held until acknowledged", viol, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule